// File: doc/BRIEF.md
# Data-Enable Panel Timing Generator

This block produces the pixel timing for a TFT panel that is driven only by a pixel clock, a data-enable strobe and parallel RGB. The panel has no horizontal or vertical sync inputs. It infers line and frame boundaries from the gaps in the enable strobe. A horizontal counter and a vertical counter run in the pixel-clock domain. They are decoded into a window that covers the visible pixels. The default geometry is 800 enabled clocks in a 1056-clock line, and 600 enabled lines followed by 28 blanked lines. The line period and the blanking length are parameters.

The pixel source connects through a request output, `pix_req`. The request acts as a ready signal with no matching valid: the source cannot stall the panel. In every clock where `pix_req` is high, the source must present the next pixel on `pix_rgb`, and the block takes it at that clock edge. There is no back-pressure in either direction. A source that cannot keep up corrupts the picture, but it cannot shift the timing. The taken pixel appears on the colour outputs one clock later, together with the enable strobe.

The block also raises a one-clock frame-start marker on the first visible pixel of each frame, and it drives a backlight enable. Elaboration is refused for parameter sets outside the panel's limits. Those limits are a line period shorter than the minimum of 1000 clocks, and a blanking length outside 10 to 110 lines.

Top module: `lcd_de_timing`

## Requirements
- R1: While `rst_n` is low, `lcd_de`, `pix_req`, `frame_start`, `backlight_en` and all colour outputs are 0.
- R2: Within every visible line, `lcd_de` is high for exactly H_ACTIVE consecutive clocks and then low for the rest of an H_TOTAL-clock line period.
- R3: Each frame holds V_ACTIVE lines with enabled pixels, followed by V_BLANK full line periods in which `lcd_de` stays low.
- R4: `pix_req` leads `lcd_de` by exactly one clock: `lcd_de` in a cycle equals `pix_req` in the cycle before.
- R5: In a cycle where `lcd_de` is high, `lcd_r`, `lcd_g` and `lcd_b` carry `pix_rgb[17:12]`, `pix_rgb[11:6]` and `pix_rgb[5:0]` respectively, as sampled at the clock edge that ended the preceding cycle, in which `pix_req` was high.
- R6: In every cycle where `lcd_de` is low, all colour outputs are 0, whatever `pix_rgb` carries.
- R7: `frame_start` is high for exactly one clock per frame, in the cycle of the first enabled pixel of line 0, and is low at all other times.
- R8: `backlight_en` rises together with the first `frame_start` after reset and then stays high until the next reset.
- R9: After reset is released, `pix_req` is high in the cycle that follows the first rising clock edge, so the first frame begins at once with no blanking interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_req | output | 1 | Pixel request, one clock ahead of the enable strobe |
| pix_rgb | input | 18 | Pixel from the source: red [17:12], green [11:6], blue [5:0] |
| lcd_de | output | 1 | Panel data-enable strobe |
| lcd_r | output | 6 | Red to the panel |
| lcd_g | output | 6 | Green to the panel |
| lcd_b | output | 6 | Blue to the panel |
| frame_start | output | 1 | One-clock marker on the first visible pixel of a frame |
| backlight_en | output | 1 | Backlight enable |

## Verification
Every output comes either from the two counters or from registers loaded from them, so a fault in the counters shows up at the ports quickly.

- A horizontal counter that skips, stalls or wraps at the wrong count changes the length of the enable burst or of the line gap. This is visible within one line period.
- A vertical counter fault moves the blanking interval or the frame-start marker. This is visible by the end of the first frame.
- A misaligned data stage shows colour values that belong to a neighbouring pixel, or non-zero colour in a gap, on the very next enabled or idle clock.

The reference model predicts every output on every clock from the cycle count since reset. A single-cycle slip is therefore reported in the cycle where it happens.

// File: rtl/lcd_de_pkg.sv
package lcd_de_pkg;

  localparam int unsigned PLANES = 3;

  typedef enum logic [1:0] {
    PLANE_B = 2'd0,
    PLANE_G = 2'd1,
    PLANE_R = 2'd2
  } plane_e;

  function automatic bit timing_ok(
    input int unsigned h_total,
    input int unsigned h_active,
    input int unsigned min_line,
    input int unsigned v_blank,
    input int unsigned min_blank,
    input int unsigned max_blank
  );
    return (h_total >= min_line) && (h_total > h_active) &&
           (v_blank >= min_blank) && (v_blank <= max_blank);
  endfunction

endpackage

// File: rtl/lcd_hv_counter.sv
module lcd_hv_counter #(
  parameter int unsigned H_TOTAL = 1056,
  parameter int unsigned V_TOTAL = 628,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt
);

  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  // Reset parks the scan on the last blank position so the first edge
  // after release lands on pixel 0 of line 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= H_LAST;
      v_cnt <= V_LAST;
    end else if (h_cnt == H_LAST) begin
      h_cnt <= '0;
      v_cnt <= (v_cnt == V_LAST) ? '0 : v_cnt + 1'b1;
    end else begin
      h_cnt <= h_cnt + 1'b1;
    end
  end

  // R2: a line ends by returning to column 0
  p_h_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == H_LAST) |=> (h_cnt == '0));

  // R3: line index advances only at a line end, by one
  p_v_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt == H_LAST && v_cnt != V_LAST) |=> (v_cnt == $past(v_cnt) + 1'b1));

  p_v_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_cnt != H_LAST) |=> $stable(v_cnt));

endmodule

// File: rtl/lcd_de_window.sv
module lcd_de_window #(
  parameter int unsigned H_ACTIVE = 800,
  parameter int unsigned H_TOTAL  = 1056,
  parameter int unsigned V_ACTIVE = 600,
  parameter int unsigned V_TOTAL  = 628,
  localparam int unsigned HW = $clog2(H_TOTAL),
  localparam int unsigned VW = $clog2(V_TOTAL)
) (
  input  logic [HW-1:0] h_cnt,
  input  logic [VW-1:0] v_cnt,
  output logic          in_window,
  output logic          frame_origin
);

  localparam logic [HW-1:0] H_END = HW'(H_ACTIVE);
  localparam logic [VW-1:0] V_END = VW'(V_ACTIVE);

  always_comb begin
    in_window    = (h_cnt < H_END) && (v_cnt < V_END);
    frame_origin = (h_cnt == '0) && (v_cnt == '0);
  end

endmodule

// File: rtl/lcd_rgb_stage.sv
module lcd_rgb_stage
  import lcd_de_pkg::*;
#(
  parameter int unsigned COLOR_W = 6,
  localparam int unsigned PIX_W = PLANES * COLOR_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           take,
  input  logic                           origin,
  input  logic [PIX_W-1:0]               pix_in,
  output logic                           de_q,
  output logic                           sof_q,
  output logic                           bl_q,
  output logic [PLANES-1:0][COLOR_W-1:0] plane_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q  <= 1'b0;
      sof_q <= 1'b0;
      bl_q  <= 1'b0;
    end else begin
      de_q  <= take;
      sof_q <= take && origin;
      if (take && origin) bl_q <= 1'b1;
    end
  end

  for (genvar c = 0; c < PLANES; c++) begin : g_plane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) plane_q[c] <= '0;
      else        plane_q[c] <= take ? pix_in[c*COLOR_W +: COLOR_W] : '0;
    end
  end

  // R6: colour is dark outside the enable strobe
  p_rgb_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !de_q |-> (plane_q == '0));

  // R7: frame marker is a single clock and sits inside the enable strobe
  p_sof_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q);

  p_sof_in_de_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |-> de_q);

  // R8: backlight never drops once lit
  p_bl_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bl_q |=> bl_q);

endmodule

// File: rtl/lcd_de_timing.sv
module lcd_de_timing
  import lcd_de_pkg::*;
#(
  parameter int unsigned H_ACTIVE  = 800,
  parameter int unsigned H_TOTAL   = 1056,
  parameter int unsigned V_ACTIVE  = 600,
  parameter int unsigned V_BLANK   = 28,
  parameter int unsigned COLOR_W   = 6,
  parameter int unsigned MIN_LINE  = 1000,
  parameter int unsigned MIN_BLANK = 10,
  parameter int unsigned MAX_BLANK = 110,
  localparam int unsigned V_TOTAL = V_ACTIVE + V_BLANK,
  localparam int unsigned PIX_W   = PLANES * COLOR_W,
  localparam int unsigned HW      = $clog2(H_TOTAL),
  localparam int unsigned VW      = $clog2(V_TOTAL)
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               pix_req,
  input  logic [PIX_W-1:0]   pix_rgb,
  output logic               lcd_de,
  output logic [COLOR_W-1:0] lcd_r,
  output logic [COLOR_W-1:0] lcd_g,
  output logic [COLOR_W-1:0] lcd_b,
  output logic               frame_start,
  output logic               backlight_en
);

  localparam bit PARAMS_OK =
    timing_ok(H_TOTAL, H_ACTIVE, MIN_LINE, V_BLANK, MIN_BLANK, MAX_BLANK);

  if (!PARAMS_OK) begin : g_param_reject
    $error("lcd_de_timing: line period or vertical blanking outside panel limits");
  end

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          origin;
  logic [PLANES-1:0][COLOR_W-1:0] planes;

  lcd_hv_counter #(
    .H_TOTAL (H_TOTAL),
    .V_TOTAL (V_TOTAL)
  ) u_counter (
    .clk   (clk),
    .rst_n (rst_n),
    .h_cnt (h_cnt),
    .v_cnt (v_cnt)
  );

  lcd_de_window #(
    .H_ACTIVE (H_ACTIVE),
    .H_TOTAL  (H_TOTAL),
    .V_ACTIVE (V_ACTIVE),
    .V_TOTAL  (V_TOTAL)
  ) u_window (
    .h_cnt        (h_cnt),
    .v_cnt        (v_cnt),
    .in_window    (pix_req),
    .frame_origin (origin)
  );

  lcd_rgb_stage #(
    .COLOR_W (COLOR_W)
  ) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (pix_req),
    .origin  (origin),
    .pix_in  (pix_rgb),
    .de_q    (lcd_de),
    .sof_q   (frame_start),
    .bl_q    (backlight_en),
    .plane_q (planes)
  );

  assign lcd_r = planes[PLANE_R];
  assign lcd_g = planes[PLANE_G];
  assign lcd_b = planes[PLANE_B];

  // R4: enable strobe trails the request by one clock
  p_de_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_de == $past(pix_req));

  // R5: visible colour is the pixel taken on the request clock
  p_rgb_taken_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pix_req) |-> ({lcd_r, lcd_g, lcd_b} == $past(pix_rgb)));

endmodule

// File: tb/lcd_de_timing_tb_top.sv
module lcd_de_timing_tb_top;

  localparam int HA = 8;
  localparam int HT = 12;
  localparam int VA = 4;
  localparam int VB = 3;
  localparam int VT = VA + VB;
  localparam int FT = HT * VT;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [17:0]   pix_rgb = '0;
  logic          pix_req, lcd_de, frame_start, backlight_en;
  logic [CW-1:0] lcd_r, lcd_g, lcd_b;

  int checks = 0;
  int fails  = 0;
  int n      = 0;
  bit done   = 1'b0;
  logic [17:0] last_drv = '0;

  always #5 clk = ~clk;

  lcd_de_timing #(
    .H_ACTIVE (HA), .H_TOTAL (HT), .V_ACTIVE (VA), .V_BLANK (VB),
    .COLOR_W (CW), .MIN_LINE (10), .MIN_BLANK (2), .MAX_BLANK (5)
  ) dut_i (
    .clk (clk), .rst_n (rst_n), .pix_req (pix_req), .pix_rgb (pix_rgb),
    .lcd_de (lcd_de), .lcd_r (lcd_r), .lcd_g (lcd_g), .lcd_b (lcd_b),
    .frame_start (frame_start), .backlight_en (backlight_en)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, n, act, exp);
    end
  endtask

  function automatic int visible(input int idx);
    int col = idx % HT;
    int row = (idx / HT) % VT;
    return (col < HA && row < VA) ? 1 : 0;
  endfunction

  function automatic logic [17:0] pattern(input int k);
    return 18'((k * 40503) ^ (k << 7) ^ 18'h2A5C3);
  endfunction

  task automatic drive_next();
    pix_rgb  = pattern(n + 11);
    last_drv = pix_rgb;
  endtask

  task automatic check_reset_state();
    check("R1 de", int'(lcd_de), 0);
    check("R1 req", int'(pix_req), 0);
    check("R1 sof", int'(frame_start), 0);
    check("R1 backlight", int'(backlight_en), 0);
    check("R1 rgb", int'({lcd_r, lcd_g, lcd_b}), 0);
  endtask

  task automatic run_cycles(input int count);
    for (int i = 0; i < count; i++) begin
      int ede, ereq, esof, ebl;
      @(posedge clk);
      n++;
      @(negedge clk);
      ereq = visible(n - 1);
      ede  = (n >= 2) ? visible(n - 2) : 0;
      esof = (n >= 2 && ((n - 2) % FT) == 0) ? 1 : 0;
      ebl  = (n >= 2) ? 1 : 0;
      if (n == 1) check("R9 first request", int'(pix_req), 1);
      else        check("R4 request", int'(pix_req), ereq);
      if (n >= 2 && (((n - 2) / HT) % VT) >= VA) check("R3 blank de", int'(lcd_de), ede);
      else                                       check("R2 line de", int'(lcd_de), ede);
      check("R7 frame_start", int'(frame_start), esof);
      check("R8 backlight", int'(backlight_en), ebl);
      if (ede == 1) begin
        check("R5 red",   int'(lcd_r), int'(last_drv[17:12]));
        check("R5 green", int'(lcd_g), int'(last_drv[11:6]));
        check("R5 blue",  int'(lcd_b), int'(last_drv[5:0]));
      end else begin
        check("R6 idle rgb", int'({lcd_r, lcd_g, lcd_b}), 0);
      end
      drive_next();
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    pix_rgb = 18'h3FFFF;
    repeat (3) @(negedge clk);
    check_reset_state();
    n = 0;
    drive_next();
    rst_n = 1'b1;
    run_cycles(3 * FT + 5);
    // reset in mid-frame, then a fresh start
    @(negedge clk);
    rst_n = 1'b0;
    pix_rgb = 18'h15A5A;
    #2;
    check_reset_state();
    repeat (2) @(negedge clk);
    check_reset_state();
    n = 0;
    drive_next();
    rst_n = 1'b1;
    run_cycles(FT + 2 * HT);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule